// File: doc/BRIEF.md
# Timer-Chip Logic Model

This block is a clocked, synthesizable model of the digital behaviour of a classic analog timer chip. Analog levels are given to it as logic inputs. These are an active-low clear, a threshold-crossed flag, an active-low trigger flag, and a control pin split into a value and a drive-enable. A combinational decode turns these inputs into set and reset requests. The requests update a single state bit on each rising clock edge.

The state bit drives two pins. One is a push-pull output that is high while the state is set. The other is an active-high enable for an open-drain discharge pull-down, asserted while the state is clear. Both pins come from their own flops and change on the same edge. Any RC timing around the block is produced by whoever drives the threshold and trigger flags.

When the control pin is floated, threshold and trigger act normally, and an asserted trigger wins over threshold. When the control pin is driven low, the trigger is masked. When it is driven high, the threshold is masked.

Top module: `timer_logic_model`

## Requirements
- R1: While `por` is high at a rising edge, after that edge `out_q` is 0 and `dis_en` is 1, whatever the other inputs are.
- R2: When `clear_n` is 0 at a rising edge, after that edge `out_q` is 0, whatever the threshold, trigger and control inputs are.
- R3: With `clear_n`=1 and `ctl_oe`=0, a `trig_n`=0 makes `out_q` 1 after the edge, even when `thresh`=1.
- R4: With `clear_n`=1, `ctl_oe`=0 and `trig_n`=1, a `thresh`=1 makes `out_q` 0 after the edge.
- R5: With `clear_n`=1, `ctl_oe`=0, `trig_n`=1 and `thresh`=0, `out_q` keeps its previous value.
- R6: With `clear_n`=1, `ctl_oe`=1 and `ctl_val`=0, `trig_n` has no effect. `thresh`=1 gives `out_q`=0 after the edge, and `thresh`=0 holds `out_q`.
- R7: With `clear_n`=1, `ctl_oe`=1 and `ctl_val`=1, `thresh` has no effect. `trig_n`=0 gives `out_q`=1 after the edge, and `trig_n`=1 holds `out_q`.
- R8: `dis_en` is always the inverse of `out_q`. Both are registered and change on the same rising edge, one cycle after the inputs that cause the change.
- R9: The decode never raises the set request and the reset request in the same cycle. When clear and trigger are both active, the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| por | input | 1 | Synchronous power-on reset, active high |
| clear_n | input | 1 | Active-low clear of the state |
| thresh | input | 1 | Threshold level crossed (1 = above) |
| trig_n | input | 1 | Active-low trigger level |
| ctl_val | input | 1 | Level driven on the control pin |
| ctl_oe | input | 1 | Control pin driven (1) or floating (0) |
| out_q | output | 1 | Push-pull output, equals the state |
| dis_en | output | 1 | Discharge pull-down enable, inverse of the state |

## Verification
The assertions assume that all five logic inputs are known and stable around every rising edge once power-on reset is released. They also assume that `por` is the only thing that puts the state back to zero outside the decode rules. The bench changes inputs only on falling edges and holds them for a full cycle. It drives every input to a known value from time zero, so each property sees clean, single-cycle stimulus. The exhaustive sweep runs each of the 32 input combinations from both a cleared state and a set state, so the hold and mask cases are exercised from either starting value.

// File: rtl/timer_logic_model.sv
module timer_logic_model (
  input  logic clk,
  input  logic por,
  input  logic clear_n,
  input  logic thresh,
  input  logic trig_n,
  input  logic ctl_val,
  input  logic ctl_oe,
  output logic out_q,
  output logic dis_en
);

  logic set_req, rst_req;

  always_comb begin
    set_req = 1'b0;
    rst_req = 1'b0;
    if (!clear_n) begin
      rst_req = 1'b1;
    end else if (!ctl_oe) begin
      if (!trig_n) set_req = 1'b1;
      else         rst_req = thresh;
    end else if (ctl_val) begin
      set_req = !trig_n;
    end else begin
      rst_req = thresh;
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      out_q  <= 1'b0;
      dis_en <= 1'b1;
    end else if (rst_req) begin
      out_q  <= 1'b0;
      dis_en <= 1'b1;
    end else if (set_req) begin
      out_q  <= 1'b1;
      dis_en <= 1'b0;
    end
  end

endmodule

module timer_logic_model_chk (
  input logic clk,
  input logic por,
  input logic clear_n,
  input logic thresh,
  input logic trig_n,
  input logic ctl_val,
  input logic ctl_oe,
  input logic out_q,
  input logic dis_en,
  input logic set_req,
  input logic rst_req
);

  p_por_r1: assert property (@(posedge clk) por |=> (!out_q && dis_en));

  p_clear_r2: assert property (@(posedge clk) disable iff (por)
    !clear_n |=> !out_q);

  p_trig_wins_r3: assert property (@(posedge clk) disable iff (por)
    (clear_n && !ctl_oe && !trig_n) |=> out_q);

  p_thresh_r4: assert property (@(posedge clk) disable iff (por)
    (clear_n && !ctl_oe && trig_n && thresh) |=> !out_q);

  p_hold_r5: assert property (@(posedge clk) disable iff (por)
    (clear_n && !ctl_oe && trig_n && !thresh) |=> $stable(out_q));

  p_low_thr_r6: assert property (@(posedge clk) disable iff (por)
    (clear_n && ctl_oe && !ctl_val && thresh) |=> !out_q);

  p_low_hold_r6: assert property (@(posedge clk) disable iff (por)
    (clear_n && ctl_oe && !ctl_val && !thresh) |=> $stable(out_q));

  p_high_trig_r7: assert property (@(posedge clk) disable iff (por)
    (clear_n && ctl_oe && ctl_val && !trig_n) |=> out_q);

  p_high_hold_r7: assert property (@(posedge clk) disable iff (por)
    (clear_n && ctl_oe && ctl_val && trig_n) |=> $stable(out_q));

  p_pair_r8: assert property (@(posedge clk) disable iff (por)
    dis_en == !out_q);

  p_excl_r9: assert property (@(posedge clk) disable iff (por)
    !(set_req && rst_req));

endmodule

bind timer_logic_model timer_logic_model_chk u_chk (
  .clk(clk), .por(por), .clear_n(clear_n), .thresh(thresh),
  .trig_n(trig_n), .ctl_val(ctl_val), .ctl_oe(ctl_oe),
  .out_q(out_q), .dis_en(dis_en), .set_req(set_req), .rst_req(rst_req)
);

// File: tb/timer_logic_model_bench.sv
module timer_logic_model_bench;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic clear_n = 1'b1, thresh = 1'b0, trig_n = 1'b0, ctl_val = 1'b0, ctl_oe = 1'b0;
  logic out_q, dis_en;

  int checks = 0;
  int errors = 0;
  logic model_q = 1'b0;

  always #5 clk = ~clk;

  timer_logic_model u_timer_logic_model (
    .clk(clk), .por(por), .clear_n(clear_n), .thresh(thresh), .trig_n(trig_n),
    .ctl_val(ctl_val), .ctl_oe(ctl_oe), .out_q(out_q), .dis_en(dis_en)
  );

  function automatic logic ref_next(logic q, logic cl, logic oe, logic cv, logic th, logic tr);
    logic th_eff, tr_eff;
    if (!cl) return 1'b0;
    th_eff = (oe && cv) ? 1'b0 : th;
    tr_eff = (oe && !cv) ? 1'b1 : tr;
    if (!tr_eff) return 1'b1;
    if (th_eff) return 1'b0;
    return q;
  endfunction

  function automatic string tag_of(logic cl, logic oe, logic cv, logic th, logic tr);
    if (!cl) return tr ? "R2" : "R2 R9";
    if (!oe) begin
      if (!tr) return "R3";
      return th ? "R4" : "R5";
    end
    return cv ? "R7" : "R6";
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic cl, input logic oe, input logic cv,
                      input logic th, input logic tr, input string tag);
    @(negedge clk);
    por = p; clear_n = cl; ctl_oe = oe; ctl_val = cv; thresh = th; trig_n = tr;
    @(posedge clk);
    model_q = p ? 1'b0 : ref_next(model_q, cl, oe, cv, th, tr);
    @(negedge clk);
    check(out_q, model_q, tag);
    check(dis_en, !model_q, {tag, " R8"});
  endtask

  initial begin
    int rises;
    logic prev;
    // R1: power-on reset wins over an active trigger
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    // R3 then R1 again from a set state
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R1");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5");

    // exhaustive decode sweep from both starting states
    for (int pre = 0; pre < 2; pre++) begin
      for (int v = 0; v < 32; v++) begin
        if (pre == 0) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
        else          step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        step(1'b0, v[4], v[3], v[2], v[1], v[0],
             tag_of(v[4], v[3], v[2], v[1], v[0]));
      end
    end

    // astable-style sequence: trigger, hold, threshold, hold
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    rises = 0;
    prev = out_q;
    for (int c = 0; c < 3; c++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
      if (out_q && !prev) rises++;
      prev = out_q;
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R4");
      prev = out_q;
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
    end
    checks++;
    if (rises != 3) begin
      errors++;
      $display("FAIL R3 R4 astable rises: got %0d expected 3", rises);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule